// File: doc/BRIEF.md
# Rotate-Right Execution Unit

This unit carries out one instruction family of an 8-bit processor: rotating a byte one place to the right. A fetch stage hands it the two opcode bytes and, when the addressing form needs one, an immediate byte, together with a start request. The operand is accumulator A, register B, or a byte in memory. Memory is reached through a 24-bit address built from a bank register, a page register and the immediate byte, or from the bank register and a 16-bit pointer register.

For memory operands the unit reads the byte over a simple synchronous byte bus and rotates it. It then writes the result back to the same address. Each addressing form has a fixed length in clock cycles. The unit raises a one-cycle done pulse in the last of those cycles. The register write enable and the new zero, carry and sign flags are presented during that pulse, and overflow passes through untouched. An opcode the unit does not recognise produces a one-cycle illegal strobe and nothing else.

Top module: `ror_exec_unit`

## Requirements
- R1: The result equals the operand rotated right by one place: old bit 0 becomes bit 7 and every other bit moves one position down (0x04 gives 0x02, 0x45 gives 0xA2, 0x84 gives 0x42, 0x01 gives 0x80).
- R2: During the done cycle, flags_out bit 0 (zero) is 1 exactly when the 8-bit result is 0x00.
- R3: During the done cycle, flags_out bit 1 (carry) and bit 3 (sign) both equal bit 7 of the result. Bit 2 (overflow) equals flags_in bit 2.
- R4: Count the cycle in which start is accepted as cycle 1. Done is high in cycle 12 for second opcode byte 0x9C (register A) and 0x9D (register B), in cycle 16 for 0x9F (pointer form), and in cycle 20 for 0x9E (page form). The first opcode byte must be 0xCE.
- R5: Done is high for exactly one cycle. reg_a_we (form 0x9C only), reg_b_we (form 0x9D only) and flags_we are high only in that cycle, and neither register enable rises for memory forms.
- R6: The page form uses address {bank, page, immediate}, with bank in bits 23:16, page in 15:8 and the immediate byte in 7:0.
- R7: The pointer form uses address {bank, pointer}, with bank in bits 23:16 and the 16-bit pointer in 15:0.
- R8: A memory form issues exactly one mem_rd in cycle 2, with data returned in the following cycle. It issues exactly one mem_wr in the cycle before done, to the same address, with mem_wdata equal to the rotated byte. Register forms issue no bus strobes.
- R9: If start is presented while idle and the first byte is not 0xCE, or the second byte is not one of 0x9C to 0x9F, illegal is high for the next cycle only. No busy, bus strobe, done or write enable follows.
- R10: While busy, including the done cycle, start is ignored: no illegal strobe appears and the running instruction keeps its length and result.
- R11: While reset is low, and in the cycle after it, busy, done, illegal, mem_rd, mem_wr and all write enables are low. Reset in the middle of an instruction abandons it without a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to execute the presented opcode |
| op_prefix | input | 8 | First opcode byte |
| op_code | input | 8 | Second opcode byte |
| op_imm | input | 8 | Immediate byte for the page form |
| reg_a | input | 8 | Current accumulator value |
| reg_b | input | 8 | Current B register value |
| addr_bank | input | 8 | Bank register, address bits 23:16 |
| addr_page | input | 8 | Page register, address bits 15:8 in the page form |
| addr_ptr | input | 16 | Pointer register, address bits 15:0 in the pointer form |
| flags_in | input | 4 | Current flags: bit0 zero, bit1 carry, bit2 overflow, bit3 sign |
| busy | output | 1 | Instruction in progress (includes the done cycle) |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle strobe for an unrecognised opcode |
| result | output | 8 | Rotated byte, valid with done |
| reg_a_we | output | 1 | Write result into A (done cycle) |
| reg_b_we | output | 1 | Write result into B (done cycle) |
| flags_we | output | 1 | Write flags_out (done cycle) |
| flags_out | output | 4 | New flags, same bit layout as flags_in |
| mem_addr | output | 24 | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |

## Verification
A wrong remaining-cycle count appears at once as a done pulse in the wrong cycle, or a write strobe that is not directly followed by done. Both are caught in the same instruction. If the operand register captures the wrong byte, or captures it in the wrong cycle, the written data, the result and the flags are wrong in the final cycles of that instruction. A wrong mode register lights the wrong write enable, or misses or adds bus strobes, and this is visible within the instruction. A latched address that drifts shows as a write address that differs from the read address. An idle/busy flag that is out of step shows up as a stray illegal strobe, or as a start that is accepted during a running instruction.

// File: rtl/ror_pkg.sv
// Package ror_pkg
// Shared encodings for the rotate-right execution unit: opcode bytes,
// addressing forms and the bit layout of the flag vector.
// Assumes 8-bit opcode bytes regardless of the data width.
package ror_pkg;

    localparam logic [7:0] OPC_PREFIX = 8'hCE;
    localparam logic [7:0] OPC_ACC    = 8'h9C;
    localparam logic [7:0] OPC_BREG   = 8'h9D;
    localparam logic [7:0] OPC_PAGE   = 8'h9E;
    localparam logic [7:0] OPC_PTR    = 8'h9F;

    // Flag vector bit positions
    localparam int FLG_Z = 0;
    localparam int FLG_C = 1;
    localparam int FLG_V = 2;
    localparam int FLG_S = 3;

    typedef enum logic [1:0] {
        FORM_ACC  = 2'd0,
        FORM_BREG = 2'd1,
        FORM_PAGE = 2'd2,
        FORM_PTR  = 2'd3
    } ror_form_e;

endpackage

// File: rtl/ror_rotate.sv
// Module ror_rotate
// Combinational rotate-right-by-one of a DATA_W-bit operand, with the
// zero indication and the top bit of the rotated value.
// Assumes DATA_W >= 2.
module ror_rotate #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] rotated,
    output logic              is_zero,
    output logic              top_bit
);
    // Rotate and derive the flag sources
    always_comb begin
        rotated = {operand[0], operand[DATA_W-1:1]};
        is_zero = (rotated == '0);
        top_bit = rotated[DATA_W-1];
    end
endmodule

// File: rtl/ror_addr_gen.sv
// Module ror_addr_gen
// Forms the memory address for the two memory forms: bank:page:immediate
// or bank:pointer. Assumes address width is three data widths.
module ror_addr_gen
    import ror_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 3 * DATA_W
) (
    input  ror_form_e           form,
    input  logic [DATA_W-1:0]   bank,
    input  logic [DATA_W-1:0]   page,
    input  logic [DATA_W-1:0]   imm,
    input  logic [2*DATA_W-1:0] ptr,
    output logic [ADDR_W-1:0]   addr
);
    // Select the address composition for the decoded form
    always_comb begin
        if (form == FORM_PAGE) addr = {bank, page, imm};
        else                   addr = {bank, ptr};
    end
endmodule

// File: rtl/ror_decode.sv
// Module ror_decode
// Recognises the prefixed rotate-right opcodes and reports the addressing
// form, whether it touches memory and its total length in cycles.
// Assumes CNT_W can hold the largest cycle count.
module ror_decode
    import ror_pkg::*;
#(
    parameter int CYC_REG  = 12,
    parameter int CYC_PTR  = 16,
    parameter int CYC_PAGE = 20,
    parameter int CNT_W    = 5
) (
    input  logic [7:0]       prefix,
    input  logic [7:0]       code,
    output logic             valid,
    output ror_form_e        form,
    output logic             is_mem,
    output logic [CNT_W-1:0] cycles
);
    // Map the second opcode byte to form and length
    always_comb begin
        valid  = (prefix == OPC_PREFIX);
        form   = FORM_ACC;
        is_mem = 1'b0;
        cycles = CNT_W'(CYC_REG);
        case (code)
            OPC_ACC:  form = FORM_ACC;
            OPC_BREG: form = FORM_BREG;
            OPC_PAGE: begin
                form   = FORM_PAGE;
                is_mem = 1'b1;
                cycles = CNT_W'(CYC_PAGE);
            end
            OPC_PTR: begin
                form   = FORM_PTR;
                is_mem = 1'b1;
                cycles = CNT_W'(CYC_PTR);
            end
            default: valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/ror_exec_unit.sv
// Module ror_exec_unit
// Executes the rotate-right instruction family. On an accepted start it
// latches form, address and (for register forms) the operand, then counts
// down the form's cycle length. Memory forms read in cycle 2, capture data
// in cycle 3 and write back in the cycle before done. Results, write enables
// and flags are registered and appear in the done cycle.
// Assumes every cycle length is at least 4 and the bus returns read data
// one cycle after the strobe.
module ror_exec_unit
    import ror_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CYC_REG  = 12,
    parameter int CYC_PTR  = 16,
    parameter int CYC_PAGE = 20,
    localparam int ADDR_W  = 3 * DATA_W,
    localparam int CNT_W   = $clog2(CYC_PAGE + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [7:0]          op_prefix,
    input  logic [7:0]          op_code,
    input  logic [DATA_W-1:0]   op_imm,
    input  logic [DATA_W-1:0]   reg_a,
    input  logic [DATA_W-1:0]   reg_b,
    input  logic [DATA_W-1:0]   addr_bank,
    input  logic [DATA_W-1:0]   addr_page,
    input  logic [2*DATA_W-1:0] addr_ptr,
    input  logic [3:0]          flags_in,
    output logic                busy,
    output logic                done,
    output logic                illegal,
    output logic [DATA_W-1:0]   result,
    output logic                reg_a_we,
    output logic                reg_b_we,
    output logic                flags_we,
    output logic [3:0]          flags_out,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata
);
    logic             dec_valid;
    ror_form_e        dec_form;
    logic             dec_mem;
    logic [CNT_W-1:0] dec_cycles;
    logic [ADDR_W-1:0] gen_addr;
    logic [DATA_W-1:0] rot_val;
    logic              rot_zero;
    logic              rot_top;

    logic              run_q;
    ror_form_e         form_q;
    logic              mem_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] opnd_q;
    logic              rd_q;
    logic              rd_pend_q;
    logic              wr_q;
    logic              done_q;
    logic              ill_q;
    logic              we_a_q;
    logic              we_b_q;
    logic [DATA_W-1:0] res_q;
    logic              zf_q;
    logic              top_q;

    ror_decode #(
        .CYC_REG (CYC_REG),
        .CYC_PTR (CYC_PTR),
        .CYC_PAGE(CYC_PAGE),
        .CNT_W   (CNT_W)
    ) decode_i (
        .prefix(op_prefix),
        .code  (op_code),
        .valid (dec_valid),
        .form  (dec_form),
        .is_mem(dec_mem),
        .cycles(dec_cycles)
    );

    ror_addr_gen #(.DATA_W(DATA_W)) addr_i (
        .form(dec_form),
        .bank(addr_bank),
        .page(addr_page),
        .imm (op_imm),
        .ptr (addr_ptr),
        .addr(gen_addr)
    );

    ror_rotate #(.DATA_W(DATA_W)) rot_i (
        .operand(opnd_q),
        .rotated(rot_val),
        .is_zero(rot_zero),
        .top_bit(rot_top)
    );

    // Sequencer: accept, count down, bus strobes, registered completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            form_q    <= FORM_ACC;
            mem_q     <= 1'b0;
            cnt_q     <= '0;
            addr_q    <= '0;
            opnd_q    <= '0;
            rd_q      <= 1'b0;
            rd_pend_q <= 1'b0;
            wr_q      <= 1'b0;
            done_q    <= 1'b0;
            ill_q     <= 1'b0;
            we_a_q    <= 1'b0;
            we_b_q    <= 1'b0;
            res_q     <= '0;
            zf_q      <= 1'b0;
            top_q     <= 1'b0;
        end else begin
            rd_q   <= 1'b0;
            wr_q   <= 1'b0;
            done_q <= 1'b0;
            ill_q  <= 1'b0;
            we_a_q <= 1'b0;
            we_b_q <= 1'b0;
            if (!run_q) begin
                if (start && !done_q) begin
                    if (dec_valid) begin
                        run_q  <= 1'b1;
                        form_q <= dec_form;
                        mem_q  <= dec_mem;
                        cnt_q  <= dec_cycles - CNT_W'(2);
                        addr_q <= gen_addr;
                        opnd_q <= (dec_form == FORM_BREG) ? reg_b : reg_a;
                        rd_q   <= dec_mem;
                    end else begin
                        ill_q <= 1'b1;
                    end
                end
            end else begin
                cnt_q     <= cnt_q - CNT_W'(1);
                rd_pend_q <= rd_q;
                if (rd_pend_q) opnd_q <= mem_rdata;
                if (mem_q && cnt_q == CNT_W'(2)) wr_q <= 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                    res_q  <= rot_val;
                    zf_q   <= rot_zero;
                    top_q  <= rot_top;
                    we_a_q <= (form_q == FORM_ACC);
                    we_b_q <= (form_q == FORM_BREG);
                end
            end
        end
    end

    // Output assembly; overflow passes straight through
    always_comb begin
        busy             = run_q | done_q;
        done             = done_q;
        illegal          = ill_q;
        result           = res_q;
        reg_a_we         = we_a_q;
        reg_b_we         = we_b_q;
        flags_we         = done_q;
        flags_out[FLG_Z] = zf_q;
        flags_out[FLG_C] = top_q;
        flags_out[FLG_V] = flags_in[FLG_V];
        flags_out[FLG_S] = top_q;
        mem_addr         = addr_q;
        mem_rd           = rd_q;
        mem_wr           = wr_q;
        mem_wdata        = rot_val;
    end
endmodule

// File: rtl/ror_exec_unit_chk.sv
// Module ror_exec_unit_chk
// Protocol checks on the ports of ror_exec_unit, attached by bind.
// Assumes the synchronous active-low reset is held at time zero.
module ror_exec_unit_chk #(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 3 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              illegal,
    input logic [DATA_W-1:0] result,
    input logic              reg_a_we,
    input logic              reg_b_we,
    input logic              flags_we,
    input logic [3:0]        flags_out,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [DATA_W-1:0] mem_wdata
);
    // R5: done never lasts two cycles
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: register writes only with done, never both
    p_we_in_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_a_we || reg_b_we || flags_we) |-> (done && $onehot0({reg_a_we, reg_b_we})));

    // R2: zero flag reflects an all-zero result
    p_zero_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> (flags_out[0] == (result == '0)));

    // R3: carry and sign follow result bit 7
    p_carry_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> (flags_out[1] == result[DATA_W-1] && flags_out[3] == result[DATA_W-1]));

    // R8: write is immediately followed by done carrying the written byte
    p_wr_then_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (done && result == $past(mem_wdata)));

    // R8: strobes are exclusive and address holds during an instruction
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr));

    // R9: illegal strobe is quiet and single
    p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!busy && !mem_rd && !mem_wr && !done));
    p_illegal_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !illegal);

    // R11: reset leaves every strobe low
    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !illegal && !mem_rd && !mem_wr && !reg_a_we && !reg_b_we));
endmodule

bind ror_exec_unit ror_exec_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .illegal  (illegal),
    .result   (result),
    .reg_a_we (reg_a_we),
    .reg_b_we (reg_b_we),
    .flags_we (flags_we),
    .flags_out(flags_out),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_wdata(mem_wdata)
);

// File: tb/ror_exec_unit_tb_top.sv
// Bench for ror_exec_unit: every operand value in every addressing form,
// the full illegal-opcode space, busy-time start hammering and reset.
module ror_exec_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  op_prefix = 8'h00;
    logic [7:0]  op_code = 8'h00;
    logic [7:0]  op_imm = 8'h00;
    logic [7:0]  reg_a = 8'h00;
    logic [7:0]  reg_b = 8'h00;
    logic [7:0]  addr_bank = 8'h00;
    logic [7:0]  addr_page = 8'h00;
    logic [15:0] addr_ptr = 16'h0000;
    logic [3:0]  flags_in = 4'h0;
    logic        busy, done, illegal, reg_a_we, reg_b_we, flags_we, mem_rd, mem_wr;
    logic [7:0]  result, mem_wdata;
    logic [3:0]  flags_out;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic [7:0]  mem_val = 8'h00;

    int n_checks = 0;
    int n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Single-location memory model: data returns the cycle after the strobe
    always @(posedge clk) if (mem_rd) mem_rdata <= mem_val;

    ror_exec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_prefix(op_prefix),
        .op_code(op_code), .op_imm(op_imm), .reg_a(reg_a), .reg_b(reg_b),
        .addr_bank(addr_bank), .addr_page(addr_page), .addr_ptr(addr_ptr),
        .flags_in(flags_in), .busy(busy), .done(done), .illegal(illegal),
        .result(result), .reg_a_we(reg_a_we), .reg_b_we(reg_b_we),
        .flags_we(flags_we), .flags_out(flags_out), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic bit quiet();
        return !busy && !done && !illegal && !mem_rd && !mem_wr && !reg_a_we && !reg_b_we && !flags_we;
    endfunction

    // Run one instruction; form 0=A 1=B 2=page 3=pointer
    task automatic run_op(input int form, input int val, input bit hammer);
        int cyc, k, rd_n, wr_n, rd_k, wr_k, expv;
        logic [23:0] rd_a, wr_a, exp_a;
        logic [7:0] wr_d;
        bit saw_ill, ovf;
        cyc  = (form < 2) ? 12 : (form == 3 ? 16 : 20);
        expv = (val / 2) + (val % 2) * 128;
        addr_bank = 8'(val ^ 8'h5A);
        addr_page = 8'(~val);
        op_imm    = 8'(val + 8'h33);
        addr_ptr  = {8'(val), 8'(val ^ 8'hC3)};
        exp_a = (form == 2) ? {addr_bank, addr_page, op_imm} : {addr_bank, addr_ptr};
        ovf = val[0] ^ val[3];
        flags_in = {val[1], ovf, val[2], val[4]};
        reg_a = (form == 0) ? 8'(val) : 8'(~val);
        reg_b = (form == 1) ? 8'(val) : 8'(val ^ 8'hFF);
        if (form >= 2) begin reg_a = 8'(~val); reg_b = 8'(~val); end
        mem_val = 8'(val);
        op_prefix = 8'hCE;
        op_code = 8'(8'h9C + form);
        start = 1'b1;
        k = 0; rd_n = 0; wr_n = 0; rd_k = 0; wr_k = 0; saw_ill = 0;
        rd_a = '0; wr_a = '0; wr_d = '0;
        while (1) begin
            step();
            k++;
            if (!hammer) start = 1'b0;
            else op_code = (k % 5 == 0) ? 8'h11 : 8'(8'h9C + ((form + k) % 4));
            if (mem_rd) begin rd_n++; rd_a = mem_addr; rd_k = k; end
            if (mem_wr) begin wr_n++; wr_a = mem_addr; wr_d = mem_wdata; wr_k = k; end
            if (illegal) saw_ill = 1;
            if (done || k >= 40) break;
        end
        start = 1'b0;
        check(k == cyc - 1, "R4 done cycle", k + 1, cyc);
        check(result == 8'(expv), "R1 rotated result", result, expv);
        check(flags_out[0] == (expv == 0), "R2 zero flag", flags_out[0], expv == 0);
        check(flags_out[1] == (expv >= 128) && flags_out[3] == (expv >= 128),
              "R3 carry/sign", flags_out, expv >= 128);
        check(flags_out[2] == ovf, "R3 overflow passthrough", flags_out[2], ovf);
        check(flags_we && reg_a_we == (form == 0) && reg_b_we == (form == 1),
              "R5 write enables", {flags_we, reg_a_we, reg_b_we}, {1'b1, form == 0, form == 1});
        if (form >= 2) begin
            check(rd_n == 1 && rd_k == 1, "R8 single read in cycle 2", rd_n * 100 + rd_k, 101);
            check(wr_n == 1 && wr_k == cyc - 2, "R8 single write before done", wr_n * 100 + wr_k, 100 + cyc - 2);
            check(wr_d == 8'(expv), "R8 write data", wr_d, expv);
            check(wr_a == rd_a, "R8 write address equals read address", wr_a, rd_a);
            if (form == 2) check(rd_a == exp_a, "R6 page address", rd_a, exp_a);
            else           check(rd_a == exp_a, "R7 pointer address", rd_a, exp_a);
        end else begin
            check(rd_n == 0 && wr_n == 0, "R8 no bus strobes for register form", rd_n + wr_n, 0);
        end
        if (hammer) check(!saw_ill, "R10 start ignored while busy", saw_ill, 0);
        step();
        check(!done && !flags_we && !reg_a_we && !reg_b_we, "R5 done lasts one cycle",
              {done, flags_we, reg_a_we, reg_b_we}, 0);
    endtask

    task automatic try_illegal(input logic [7:0] pre, input logic [7:0] code);
        op_prefix = pre;
        op_code = code;
        start = 1'b1;
        step();
        start = 1'b0;
        check(illegal && !busy && !mem_rd && !mem_wr && !done && !reg_a_we && !reg_b_we,
              "R9 illegal strobe only", {illegal, busy, mem_rd, done}, 4'b1000);
        step();
        check(quiet(), "R9 illegal lasts one cycle, no follow-on", {illegal, busy, done}, 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        // R11: quiet during and right after reset
        @(negedge clk);
        check(quiet(), "R11 quiet in reset", {busy, done, mem_rd, mem_wr}, 0);
        step();
        step();
        rst_n = 1'b1;
        step();
        check(quiet(), "R11 quiet after reset", {busy, done, mem_rd, mem_wr}, 0);

        // Reference vectors
        run_op(0, 8'h04, 1'b0);
        run_op(1, 8'h45, 1'b0);
        run_op(1, 8'h84, 1'b0);
        run_op(3, 8'h01, 1'b0);

        // Full sweep of operands over every form
        for (int v = 0; v < 256; v++)
            for (int f = 0; f < 4; f++)
                run_op(f, v, (v % 16) == 5);

        // R9: every unrecognised second byte, plus wrong prefixes
        for (int c = 0; c < 256; c++)
            if (c < 8'h9C || c > 8'h9F) try_illegal(8'hCE, 8'(c));
        try_illegal(8'h00, 8'h9C);
        try_illegal(8'hCF, 8'h9F);
        try_illegal(8'hCD, 8'h9E);

        // R11: reset in mid-instruction abandons it
        op_prefix = 8'hCE;
        op_code = 8'h9F;
        start = 1'b1;
        step();
        start = 1'b0;
        repeat (5) step();
        rst_n = 1'b0;
        step();
        check(quiet(), "R11 reset aborts instruction", {busy, done, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        begin
            bit saw_done = 0;
            for (int i = 0; i < 25; i++) begin
                step();
                if (done || busy || mem_wr) saw_done = 1;
            end
            check(!saw_done, "R11 no done after abandoned instruction", saw_done, 0);
        end
        run_op(2, 8'hA5, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule